// File: doc/BRIEF.md
# Free-Running Dual-Compare Toggle Timer

This block is a 16-bit up-counter that runs without ever being cleared by a compare match. Two compare channels watch it. Software sets a run bit, and from then on the counter advances by one on every system-clock cycle in which the count-clock enable (a prescaler tick from outside) is high. Each channel holds a compare value. Whenever the counter steps onto that value, the channel gives a one-cycle match interrupt pulse and inverts its own toggle pin. Because the counter is never cleared by a match, the toggle pins form square waves whose edges fall at chosen points of a 65536-count period.

When the run bit rises, the counter starts again from zero and both toggle pins invert once. When the counter steps from its top value to zero, the block gives an overflow interrupt pulse and sets a sticky overflow flag. Software clears that flag with a clear strobe. A compare value can be rewritten while the counter runs, and the new value takes effect at once, with no shadow register. The current count is available on an output port.

Top module: `cmp_toggle_timer`

## Requirements
- R1: After reset, the count, both toggle pins, both match pulses, the overflow pulse, the overflow flag and both compare values are zero, and the counter is stopped.
- R2: In the first cycle that the run input is high after being low, the count is loaded with 0 whatever the tick input is, and both toggle pins invert. No interrupt pulse comes from this start.
- R3: When a count step makes the count equal to a channel's compare value, that channel's match pulse is high for exactly the one cycle in which the new count is first visible, and that channel's toggle pin inverts in the same cycle.
- R4: While running, the count rises by one only in cycles where the tick input is high, and otherwise it holds. A compare match never clears or reloads the count.
- R5: A tick while the count is 16'hFFFF makes the count 0 and raises the overflow pulse for exactly one cycle, in the same cycle that the zero count appears. A compare value of 0 matches on this wrap.
- R6: The overflow flag is set by every overflow and stays set until a clear strobe arrives in a cycle with no new overflow. If the clear and an overflow fall in the same cycle, the flag stays set.
- R7: A write to compare channel cmp_sel (0 or 1) takes effect for the count steps in later cycles. A count step in the same cycle as the write is compared against the old value.
- R8: While the run input is low, the count is held at 0, the toggle pins keep their levels, and no match or overflow pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| cnt_run | input | 1 | Run control bit; a rising level starts counting from zero |
| cmp_we | input | 1 | Write strobe for a compare value |
| cmp_sel | input | 1 | Channel addressed by the write (0 or 1) |
| cmp_wdata | input | 16 | Compare value to write |
| ovf_clr | input | 1 | Clear strobe for the sticky overflow flag |
| count | output | 16 | Current counter value |
| tog_out | output | 2 | Toggle pins, bit i for channel i |
| match_irq | output | 2 | One-cycle compare-match pulses, bit i for channel i |
| ovf_irq | output | 1 | One-cycle overflow pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
If the stored run state is wrong, the fault shows in the first cycle after a run edge: the count fails to reload, or the toggle pins fail to invert together. If a channel holds a wrong compare value or compares against the wrong count, the match pulse and the toggle edge appear on a different count from the one the bench predicts. The bench compares every cycle, so such a fault is reported in the same cycle the bad pulse appears. A flag fault near the wrap can only be seen once 65536 ticks have passed. For this reason the bench drives two complete wraps, and it lines up a clear strobe with the second wrap.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int CMT_WIDTH    = 16;
  localparam int CMT_CHANNELS = 2;

  // Phase of the counter as seen in the current cycle.
  typedef enum logic [1:0] {
    CMT_IDLE  = 2'd0,
    CMT_START = 2'd1,
    CMT_RUN   = 2'd2
  } cmt_phase_e;

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int W = CMT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         start_evt,
  output logic         adv_evt,
  output logic         wrap_evt
);

  function automatic logic [W-1:0] step_up(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  function automatic logic at_top(input logic [W-1:0] v);
    return &v;
  endfunction

  logic       run_q;
  cmt_phase_e phase;

  always_comb begin
    if (!run)       phase = CMT_IDLE;
    else if (!run_q) phase = CMT_START;
    else            phase = CMT_RUN;
  end

  assign start_evt = (phase == CMT_START);
  assign adv_evt   = (phase == CMT_RUN) && tick;
  assign cnt_nxt   = step_up(cnt);
  assign wrap_evt  = adv_evt && at_top(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else begin
      run_q <= run;
      unique case (phase)
        CMT_IDLE:  cnt <= '0;
        CMT_START: cnt <= '0;
        default:   if (tick) cnt <= cnt_nxt;
      endcase
    end
  end

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !at_top(cnt)) |=> (cnt == $past(cnt) + W'(1))); // R4

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !tick) |=> $stable(cnt)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R8

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int W = CMT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_evt,
  input  logic         adv_evt,
  input  logic [W-1:0] cnt_nxt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_val,
  output logic         tog,
  output logic         match_irq
);

  function automatic logic hits(input logic step, input logic [W-1:0] nxt,
                                input logic [W-1:0] ref_v);
    return step && (nxt == ref_v);
  endfunction

  logic match_evt;
  logic flip_evt;

  assign match_evt = hits(adv_evt, cnt_nxt, cmp_val);
  assign flip_evt  = match_evt || start_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val   <= '0;
      tog       <= 1'b0;
      match_irq <= 1'b0;
    end else begin
      if (wr_en) cmp_val <= wr_data;
      if (flip_evt) tog <= ~tog;
      match_irq <= match_evt;
    end
  end

  AST_START_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (tog != $past(tog))); // R2

  AST_MATCH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> (tog != $past(tog))); // R3

  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !match_irq); // R2

endmodule

// File: rtl/cmt_ovf.sv
module cmt_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic clr,
  output logic irq,
  output logic flag
);

  function automatic logic flag_next(input logic cur, input logic set_i,
                                     input logic clr_i);
    return set_i ? 1'b1 : (clr_i ? 1'b0 : cur);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      flag <= 1'b0;
    end else begin
      irq  <= wrap_evt;
      flag <= flag_next(flag, wrap_evt, clr);
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && clr) |=> flag); // R6

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R6

endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import cmt_pkg::*;
#(
  parameter  int W   = CMT_WIDTH,
  parameter  int NCH = CMT_CHANNELS,
  localparam int SW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_tick,
  input  logic           cnt_run,
  input  logic           cmp_we,
  input  logic [SW-1:0]  cmp_sel,
  input  logic [W-1:0]   cmp_wdata,
  input  logic           ovf_clr,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] tog_out,
  output logic [NCH-1:0] match_irq,
  output logic           ovf_irq,
  output logic           ovf_flag
);

  logic [W-1:0] cnt_nxt;
  logic         start_evt;
  logic         adv_evt;
  logic         wrap_evt;
  logic [W-1:0] cmp_val [NCH];

  cmt_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cnt_tick),
    .run       (cnt_run),
    .cnt       (count),
    .cnt_nxt   (cnt_nxt),
    .start_evt (start_evt),
    .adv_evt   (adv_evt),
    .wrap_evt  (wrap_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_this;
    assign wr_this = cmp_we && (cmp_sel == SW'(i));

    cmt_channel #(.W(W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_evt (start_evt),
      .adv_evt   (adv_evt),
      .cnt_nxt   (cnt_nxt),
      .wr_en     (wr_this),
      .wr_data   (cmp_wdata),
      .cmp_val   (cmp_val[i]),
      .tog       (tog_out[i]),
      .match_irq (match_irq[i])
    );

    AST_MATCH_ON_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq[i] |-> (count == $past(cmp_val[i]))); // R3
  end

  cmt_ovf u_ovf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_evt (wrap_evt),
    .clr      (ovf_clr),
    .irq      (ovf_irq),
    .flag     (ovf_flag)
  );

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (count == '0)); // R5

  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R5

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |=> (match_irq == '0) && !ovf_irq); // R8

  AST_STOPPED_TOG: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |=> $stable(tog_out)); // R8

endmodule

// File: tb/tb_cmp_toggle_timer.sv
`timescale 1ns/1ps
module tb_cmp_toggle_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0, cnt_run = 1'b0, cmp_we = 1'b0, ovf_clr = 1'b0;
  logic [0:0]  cmp_sel = '0;
  logic [15:0] cmp_wdata = '0;
  logic [15:0] count;
  logic [1:0]  tog_out, match_irq;
  logic        ovf_irq, ovf_flag;

  always #2.5 clk = ~clk;

  cmp_toggle_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_run(cnt_run),
    .cmp_we(cmp_we), .cmp_sel(cmp_sel), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr),
    .count(count), .tog_out(tog_out), .match_irq(match_irq),
    .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [15:0] cnt;
    logic [1:0]  tog;
    logic [1:0]  mi;
    logic        oi;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state kept by the driver
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_tog = '0;
  logic        m_fl = 1'b0;
  logic        m_runq = 1'b0;
  logic [15:0] m_cmp [2] = '{16'h0, 16'h0};

  task automatic step(input logic t, input logic r, input logic we,
                      input logic sel, input logic [15:0] d, input logic c,
                      input string tag);
    exp_t e;
    logic first, moving;
    logic [15:0] up;
    @(negedge clk);
    cnt_tick = t; cnt_run = r; cmp_we = we; cmp_sel = sel; cmp_wdata = d; ovf_clr = c;
    first  = r && !m_runq;
    moving = r && m_runq && t;
    up     = m_cnt + 16'd1;
    e.mi[0] = moving && (up == m_cmp[0]);
    e.mi[1] = moving && (up == m_cmp[1]);
    e.oi    = moving && (m_cnt == 16'hFFFF);
    if (!r || first) m_cnt = 16'h0;
    else if (moving) m_cnt = up;
    if (first) m_tog = ~m_tog;
    else m_tog = m_tog ^ e.mi;
    if (e.oi) m_fl = 1'b1;
    else if (c) m_fl = 1'b0;
    if (we) m_cmp[sel] = d;
    m_runq = r;
    e.cnt = m_cnt; e.tog = m_tog; e.fl = m_fl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, 1, 0, 0, 16'h0, 0, tag);
  endtask

  // Monitor: pops one expected item per clock and compares
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      #1;
      e = exp_q.pop_front();
      checks++;
      if (count !== e.cnt || tog_out !== e.tog || match_irq !== e.mi ||
          ovf_irq !== e.oi || ovf_flag !== e.fl) begin
        errors++;
        $display("FAIL %s: got cnt=%h tog=%b mi=%b oi=%b fl=%b exp cnt=%h tog=%b mi=%b oi=%b fl=%b",
                 e.tag, count, tog_out, match_irq, ovf_irq, ovf_flag,
                 e.cnt, e.tog, e.mi, e.oi, e.fl);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (count !== 16'h0 || tog_out !== 2'b00 || match_irq !== 2'b00 ||
        ovf_irq !== 1'b0 || ovf_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1: got cnt=%h tog=%b mi=%b oi=%b fl=%b exp all zero",
               count, tog_out, match_irq, ovf_irq, ovf_flag);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: compare values reset to zero, so a start with no writes gives no match
    step(0, 1, 0, 0, 16'h0, 0, "R1");
    step(0, 0, 0, 0, 16'h0, 0, "R8");
    // Program channel 0 = 5 and channel 1 = 9 while stopped
    step(0, 0, 1, 0, 16'd5, 0, "R7");
    step(0, 0, 1, 1, 16'd9, 0, "R7");
    // R2: start without a tick, both pins invert
    step(0, 1, 0, 0, 16'h0, 0, "R2");
    // R3 / R4: continuous ticks through both matches
    ticks(12, "R3");
    // R4: ticks with gaps
    for (int k = 0; k < 10; k++) step(k[0], 1, 0, 0, 16'h0, 0, "R4");
    // R7: write channel 1 one step ahead together with a tick (old value applies)
    step(1, 1, 1, 1, m_cnt + 16'd1, 0, "R7");
    step(1, 1, 1, 0, m_cnt + 16'd2, 0, "R7");
    ticks(4, "R7");
    // R8: stop, pins hold, then restart
    step(1, 0, 0, 0, 16'h0, 0, "R8");
    ticks(0, "R8");
    step(1, 0, 0, 0, 16'h0, 0, "R8");
    step(1, 1, 0, 0, 16'h0, 0, "R2");
    // R5: channel 0 at zero, channel 1 at top, run past the wrap
    step(1, 1, 1, 0, 16'h0, 0, "R5");
    step(1, 1, 1, 1, 16'hFFFF, 0, "R5");
    while (m_cnt != 16'hFFFF) step(1, 1, 0, 0, 16'h0, 0, "R5");
    ticks(3, "R5");
    // R6: flag holds, clears on strobe
    ticks(2, "R6");
    step(1, 1, 0, 0, 16'h0, 1, "R6");
    ticks(2, "R6");
    // R6: clear and overflow in the same cycle; overflow wins
    while (m_cnt != 16'hFFFF) step(1, 1, 0, 0, 16'h0, 0, "R4");
    step(1, 1, 0, 0, 16'h0, 1, "R6");
    ticks(2, "R6");
    step(0, 1, 0, 0, 16'h0, 1, "R6");
    step(0, 1, 0, 0, 16'h0, 0, "R6");
    step(0, 0, 0, 0, 16'h0, 0, "R8");
    ticks(0, "R8");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule